// File: doc/BRIEF.md
# Sleep-State Sequencer with Wakeup Sources

This block steers a small processor core through three power states: running, a light sleep and a deep sleep. In light sleep the oscillator and the periodic wake timer keep going while the core and its general timers freeze. In deep sleep every clock is gated and the watchdog is turned off. The block has no data path. Every pin is a plain control or status signal, so it has no valid/ready handshake. The enables it drives are levels that the clock-gating cells, the timers and the watchdog of the surrounding chip consume.

Software asks for deep sleep by writing a 1 to the halt control bit, and asks for light sleep with a separate request pulse. Three things end deep sleep: a selected edge on an enabled line of the wakeup port, a rising edge on the clock-output pin when the clock source is R/C or external, or the asynchronous reset. A port or clock-pin wakeup does not restart the core at once. The block first holds the core stalled while it counts a fixed number of oscillator ticks, so that the oscillator can settle. Light sleep ends on the terminal count of the wake timer or on a port wakeup, with no settling count.

A clock monitor can still pull the watchdog output low while the core is halted. Its enable can be changed only by the first write to the watchdog service register after reset.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: While `rst_n` is low, from any state and with no settling delay, the block is in run (`mode`=0). Its enables are 1, `core_stall`=0, `wake_done`=0 and `wdout_n`=1. The clock monitor is enabled again and its one-time write is made available again.
- R2: In run, a cycle with `halt_wr`=1 and `halt_wdata`=1 enters halt (`mode`=2) on the next cycle. A write with `halt_wdata`=0 has no effect. A halt write takes precedence over a simultaneous `idle_req`.
- R3: In run, `idle_req`=1 enters idle (`mode`=1) on the next cycle.
- R4: The state code `mode` is 0 run, 1 idle, 2 halt and 3 settling. The outputs {`core_clk_en`,`timer_en`,`idle_tmr_en`,`wdog_en`,`core_stall`} are 11110 in run, 00110 in idle, 00000 in halt and 00101 in settling.
- R5: `wdout_n` is 0 exactly while in halt with the clock monitor enabled.
- R6: The first `cmon_wr` after reset sets the clock-monitor enable to `cmon_wdata`. Every later `cmon_wr` is ignored until the next reset.
- R7: Port line i raises a wakeup when `wake_en[i]`=1 and the line shows an edge of the selected polarity: `wake_fall[i]`=1 selects falling, 0 selects rising. In halt, such an edge moves the block to settling on the next cycle. Edges of the other polarity and edges on disabled lines have no effect.
- R8: A rising edge of `clko_pin` in halt moves the block to settling only when `clk_src_rc`=1. With `clk_src_rc`=0 it is ignored.
- R9: Settling returns to run on the cycle after exactly SETTLE_TICKS `tick` pulses have been counted in settling. `wake_done` is high for that one cycle. Ticks in halt are not counted, and each settling period starts its count from zero.
- R10: Idle returns to run, without settling and without `wake_done`, after IDLE_TICKS ticks or on a port wakeup. A `clko_pin` edge does not end idle. Each idle period starts its count from zero.
- R11: `halt_wr` and `idle_req` are ignored outside run. Wakeup events are ignored in run and in settling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on block clock |
| rst_n | input | 1 | Asynchronous active-low reset, also the reset wakeup |
| halt_wr | input | 1 | Write strobe of the halt control bit |
| halt_wdata | input | 1 | Value written to the halt control bit |
| idle_req | input | 1 | Request for idle |
| tick | input | 1 | One-cycle oscillator-derived tick |
| wake_pins | input | NWAKE | Wakeup port lines |
| wake_en | input | NWAKE | Per-line wakeup enable |
| wake_fall | input | NWAKE | Per-line edge select, 1 = falling |
| clko_pin | input | 1 | Level of the clock-output pin |
| clk_src_rc | input | 1 | 1 = R/C or external clock, 0 = crystal |
| cmon_wr | input | 1 | Write strobe of the watchdog service register |
| cmon_wdata | input | 1 | Clock-monitor enable value carried by that write |
| mode | output | 2 | Current power state code |
| core_clk_en | output | 1 | Core clock enable |
| timer_en | output | 1 | General timer enable |
| idle_tmr_en | output | 1 | Periodic wake timer enable |
| wdog_en | output | 1 | Watchdog logic enable |
| core_stall | output | 1 | Core held stalled while the oscillator settles |
| wake_done | output | 1 | One-cycle pulse when settling ends |
| wdout_n | output | 1 | Watchdog output, driven low by the clock monitor in halt |

## Verification
The bench sweeps every wakeup line under both edge polarities, enabled and disabled. Before each correct edge it applies an edge of the wrong polarity, so a design that ignores the polarity select or the per-line enable would leave halt too early or never leave it. The clock-pin wakeup is tried with both clock sources, and ticks are offered during halt. Settling and idle are counted to one tick short of their limits and then to the limit, which exposes off-by-one counts, a counter that is not cleared on entry, or a `wake_done` raised after idle. The one-time monitor write, the priority of halt over idle, and reset taken in the middle of halt and of settling are each checked at the output pins.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [1:0] {
    PM_RUN    = 2'd0,
    PM_IDLE   = 2'd1,
    PM_HALT   = 2'd2,
    PM_SETTLE = 2'd3
  } pm_e;

  typedef struct packed {
    logic core;
    logic tmr;
    logic itmr;
    logic wdog;
    logic stall;
  } gate_t;

  function automatic gate_t gate_of(pm_e s);
    gate_t g;
    g = '0;
    case (s)
      PM_RUN:    begin g.core = 1'b1; g.tmr = 1'b1; g.itmr = 1'b1; g.wdog = 1'b1; end
      PM_IDLE:   begin g.itmr = 1'b1; g.wdog = 1'b1; end
      PM_HALT:   g = '0;
      PM_SETTLE: begin g.itmr = 1'b1; g.stall = 1'b1; end
      default:   g = '0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] pins,
  input  logic [NW-1:0] en,
  input  logic [NW-1:0] fall,
  input  logic          clko,
  input  logic          clko_ok,
  output logic          port_evt,
  output logic          clko_evt
);

  logic [NW-1:0] pins_q;
  logic          clko_q;
  logic          armed;
  logic [NW-1:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= '0;
      clko_q <= 1'b0;
      armed  <= 1'b0;
    end else begin
      pins_q <= pins;
      clko_q <= clko;
      armed  <= 1'b1;
    end
  end

  // One edge detector per port line, polarity chosen per line
  for (genvar i = 0; i < NW; i++) begin : g_line
    assign hit[i] = en[i] & (fall[i] ? (pins_q[i] & ~pins[i])
                                     : (~pins_q[i] & pins[i]));
  end

  assign port_evt = armed & (|hit);
  assign clko_evt = armed & clko_ok & clko & ~clko_q;

  assert_port_evt_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    port_evt |-> (pins != $past(pins)) && (en != '0));

  assert_clko_needs_rc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clko_evt |-> clko_ok && $rose(clko));

endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
  parameter int IDLE_TICKS   = 4096,
  parameter int SETTLE_TICKS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_on,
  input  logic sel_settle,
  input  logic clr,
  input  logic tick,
  output logic expire
);

  localparam int LMAX = (IDLE_TICKS > SETTLE_TICKS) ? IDLE_TICKS : SETTLE_TICKS;
  localparam int CW   = $clog2(LMAX + 1);
  localparam logic [CW-1:0] IDLE_LAST   = CW'(IDLE_TICKS - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_TICKS - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last   = sel_settle ? SETTLE_LAST : IDLE_LAST;
  assign expire = count_on & tick & (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clr)             cnt <= '0;
    else if (count_on & tick) cnt <= cnt + 1'b1;
  end

  assert_cnt_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count_on |-> cnt <= last);

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  halt_wr,
  input  logic  halt_wdata,
  input  logic  idle_req,
  input  logic  port_evt,
  input  logic  clko_evt,
  input  logic  expire,
  input  logic  cmon_wr,
  input  logic  cmon_wdata,
  output pm_e   st,
  output logic  clr,
  output logic  count_on,
  output logic  sel_settle,
  output logic  wake_done,
  output gate_t gates,
  output logic  wdout_n
);

  pm_e  st_q, st_d;
  logic done_q;
  logic cmon_en_q, cmon_lock_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      PM_RUN: begin
        if (halt_wr && halt_wdata) st_d = PM_HALT;
        else if (idle_req)         st_d = PM_IDLE;
      end
      PM_IDLE:   if (expire || port_evt)   st_d = PM_RUN;
      PM_HALT:   if (port_evt || clko_evt) st_d = PM_SETTLE;
      PM_SETTLE: if (expire)               st_d = PM_RUN;
      default:   st_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PM_RUN;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == PM_SETTLE) && expire;
    end
  end

  // Clock-monitor enable: one write after reset, then frozen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmon_en_q   <= 1'b1;
      cmon_lock_q <= 1'b0;
    end else if (cmon_wr && !cmon_lock_q) begin
      cmon_en_q   <= cmon_wdata;
      cmon_lock_q <= 1'b1;
    end
  end

  assign st         = st_q;
  assign clr        = (st_d != st_q);
  assign count_on   = (st_q == PM_IDLE) || (st_q == PM_SETTLE);
  assign sel_settle = (st_q == PM_SETTLE);
  assign wake_done  = done_q;
  assign gates      = gate_of(st_q);
  assign wdout_n    = !((st_q == PM_HALT) && cmon_en_q);

  assert_halt_exits_to_settle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == PM_HALT && st_q != PM_HALT) |-> st_q == PM_SETTLE);

  assert_done_follows_settle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (st_q == PM_RUN) && ($past(st_q) == PM_SETTLE));

  assert_idle_exit_no_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == PM_IDLE) |-> !done_q);

  assert_cmon_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmon_lock_q && $past(cmon_lock_q)) |-> $stable(cmon_en_q));

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import pwr_pkg::*;
#(
  parameter int NWAKE        = 8,
  parameter int IDLE_TICKS   = 4096,
  parameter int SETTLE_TICKS = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_wr,
  input  logic             halt_wdata,
  input  logic             idle_req,
  input  logic             tick,
  input  logic [NWAKE-1:0] wake_pins,
  input  logic [NWAKE-1:0] wake_en,
  input  logic [NWAKE-1:0] wake_fall,
  input  logic             clko_pin,
  input  logic             clk_src_rc,
  input  logic             cmon_wr,
  input  logic             cmon_wdata,
  output logic [1:0]       mode,
  output logic             core_clk_en,
  output logic             timer_en,
  output logic             idle_tmr_en,
  output logic             wdog_en,
  output logic             core_stall,
  output logic             wake_done,
  output logic             wdout_n
);

  logic  port_evt, clko_evt, expire;
  logic  clr, count_on, sel_settle;
  pm_e   st;
  gate_t gates;

  pwr_wake_detect #(.NW(NWAKE)) u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .pins     (wake_pins),
    .en       (wake_en),
    .fall     (wake_fall),
    .clko     (clko_pin),
    .clko_ok  (clk_src_rc),
    .port_evt (port_evt),
    .clko_evt (clko_evt)
  );

  pwr_settle_timer #(.IDLE_TICKS(IDLE_TICKS), .SETTLE_TICKS(SETTLE_TICKS)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_on   (count_on),
    .sel_settle (sel_settle),
    .clr        (clr),
    .tick       (tick),
    .expire     (expire)
  );

  pwr_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt_wr    (halt_wr),
    .halt_wdata (halt_wdata),
    .idle_req   (idle_req),
    .port_evt   (port_evt),
    .clko_evt   (clko_evt),
    .expire     (expire),
    .cmon_wr    (cmon_wr),
    .cmon_wdata (cmon_wdata),
    .st         (st),
    .clr        (clr),
    .count_on   (count_on),
    .sel_settle (sel_settle),
    .wake_done  (wake_done),
    .gates      (gates),
    .wdout_n    (wdout_n)
  );

  assign mode        = st;
  assign core_clk_en = gates.core;
  assign timer_en    = gates.tmr;
  assign idle_tmr_en = gates.itmr;
  assign wdog_en     = gates.wdog;
  assign core_stall  = gates.stall;

  assert_wdout_only_when_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wdout_n |-> !wdog_en && !core_clk_en && !idle_tmr_en);

  assert_stall_blocks_core_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |-> !core_clk_en && !wdog_en);

endmodule

// File: tb/pwr_sleep_ctrl_test.sv
module pwr_sleep_ctrl_test;

  localparam int NW = 4;
  localparam int IT = 6;
  localparam int ST = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          halt_wr = 1'b0, halt_wdata = 1'b0, idle_req = 1'b0, tick = 1'b0;
  logic [NW-1:0] wake_pins = '0, wake_en = '0, wake_fall = '0;
  logic          clko_pin = 1'b0, clk_src_rc = 1'b0, cmon_wr = 1'b0, cmon_wdata = 1'b0;
  logic [1:0]    mode;
  logic          core_clk_en, timer_en, idle_tmr_en, wdog_en, core_stall, wake_done, wdout_n;

  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  pwr_sleep_ctrl #(.NWAKE(NW), .IDLE_TICKS(IT), .SETTLE_TICKS(ST)) uut (
    .clk(clk), .rst_n(rst_n), .halt_wr(halt_wr), .halt_wdata(halt_wdata),
    .idle_req(idle_req), .tick(tick), .wake_pins(wake_pins), .wake_en(wake_en),
    .wake_fall(wake_fall), .clko_pin(clko_pin), .clk_src_rc(clk_src_rc),
    .cmon_wr(cmon_wr), .cmon_wdata(cmon_wdata), .mode(mode),
    .core_clk_en(core_clk_en), .timer_en(timer_en), .idle_tmr_en(idle_tmr_en),
    .wdog_en(wdog_en), .core_stall(core_stall), .wake_done(wake_done), .wdout_n(wdout_n)
  );

  function automatic int exp_gates(int m);
    case (m)
      0:       return 5'b11110;
      1:       return 5'b00110;
      2:       return 5'b00000;
      default: return 5'b00101;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_mode(string req, int m);
    check(req, int'(mode), m);
    check(req, int'({core_clk_en, timer_en, idle_tmr_en, wdog_en, core_stall}), exp_gates(m));
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic tick1();
    tick = 1'b1;
    step();
    tick = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      tick1();
      step();
    end
  endtask

  task automatic enter_halt();
    halt_wr = 1'b1; halt_wdata = 1'b1;
    step();
    halt_wr = 1'b0; halt_wdata = 1'b0;
  endtask

  task automatic enter_idle();
    idle_req = 1'b1;
    step();
    idle_req = 1'b0;
  endtask

  task automatic clko_wake();
    clko_pin = 1'b1;
    step();
    clko_pin = 1'b0;
  endtask

  task automatic settle_out(string req);
    ticks(ST - 1);
    chk_mode(req, 3);
    check(req, int'(wake_done), 0);
    tick1();
    chk_mode(req, 0);
    check(req, int'(wake_done), 1);
    step();
    check(req, int'(wake_done), 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) step();
    // R1 reset state
    chk_mode("R1", 0);
    check("R1", int'(wake_done), 0);
    check("R1", int'(wdout_n), 1);
    rst_n = 1'b1;
    step();
    chk_mode("R1", 0);

    // R2 write of 0 ignored, then halt over idle
    halt_wr = 1'b1; halt_wdata = 1'b0;
    step();
    halt_wr = 1'b0;
    chk_mode("R2", 0);
    halt_wr = 1'b1; halt_wdata = 1'b1; idle_req = 1'b1;
    step();
    halt_wr = 1'b0; halt_wdata = 1'b0; idle_req = 1'b0;
    chk_mode("R2", 2);
    check("R5", int'(wdout_n), 0);

    // R11 requests in halt ignored; R9 ticks in halt not counted
    enter_idle();
    chk_mode("R11", 2);
    ticks(2 * ST);
    chk_mode("R9", 2);

    // R8 clock-pin wakeup with crystal ignored, with R/C accepted
    clk_src_rc = 1'b0;
    clko_wake();
    chk_mode("R8", 2);
    step();
    chk_mode("R8", 2);
    clk_src_rc = 1'b1;
    clko_wake();
    chk_mode("R8", 3);
    check("R5", int'(wdout_n), 1);
    enter_halt();
    chk_mode("R11", 3);
    settle_out("R9");

    // R3 / R10 idle exits on terminal count
    enter_idle();
    chk_mode("R3", 1);
    ticks(IT - 1);
    chk_mode("R10", 1);
    tick1();
    chk_mode("R10", 0);
    check("R10", int'(wake_done), 0);
    step();

    // R10 clock pin ignored in idle, port wakeup exits
    wake_en = 4'b0001; wake_fall = '0;
    enter_idle();
    ticks(2);
    clko_wake();
    chk_mode("R10", 1);
    wake_pins[0] = 1'b1;
    step();
    chk_mode("R10", 0);
    check("R10", int'(wake_done), 0);
    wake_pins[0] = 1'b0;
    step();
    enter_idle();
    ticks(IT - 1);
    chk_mode("R10", 1);
    tick1();
    chk_mode("R10", 0);
    wake_en = '0;

    // R11 port edge in run ignored
    wake_en = 4'b1111;
    wake_pins = 4'b1111;
    step();
    chk_mode("R11", 0);
    wake_pins = '0;
    step();
    wake_en = '0;

    // R7 sweep: every line, both polarities, enabled and disabled
    for (int p = 0; p < NW; p++) begin
      for (int pol = 0; pol < 2; pol++) begin
        for (int en = 0; en < 2; en++) begin
          logic s;
          s = pol[0];
          wake_fall = {NW{pol[0]}};
          wake_en = (en != 0) ? NW'(1 << p) : (~NW'(1 << p));
          wake_pins[p] = ~s;
          step();
          enter_halt();
          chk_mode("R7", 2);
          wake_pins[p] = s;
          step();
          chk_mode("R7", 2);
          wake_pins[p] = ~s;
          step();
          chk_mode("R7", (en != 0) ? 3 : 2);
          if (en == 0) begin
            clko_wake();
            chk_mode("R8", 3);
          end
          settle_out("R9");
          wake_pins[p] = 1'b0;
          wake_en = '0;
          step();
        end
      end
    end

    // R6 one-time clock-monitor write
    cmon_wr = 1'b1; cmon_wdata = 1'b0;
    step();
    cmon_wr = 1'b0;
    enter_halt();
    check("R6", int'(wdout_n), 1);
    clko_wake();
    settle_out("R9");
    cmon_wr = 1'b1; cmon_wdata = 1'b1;
    step();
    cmon_wr = 1'b0;
    enter_halt();
    check("R6", int'(wdout_n), 1);

    // R1 reset out of halt and out of settling
    rst_n = 1'b0;
    #1;
    chk_mode("R1", 0);
    check("R1", int'(wdout_n), 1);
    step();
    rst_n = 1'b1;
    step();
    enter_halt();
    check("R1", int'(wdout_n), 0);
    clko_wake();
    chk_mode("R8", 3);
    rst_n = 1'b0;
    #1;
    chk_mode("R1", 0);
    check("R1", int'(wake_done), 0);
    step();
    rst_n = 1'b1;
    step();
    chk_mode("R1", 0);

    summary();
    $finish;
  end

endmodule